// File: doc/BRIEF.md
# Execute Stage: ALU, Condition Flags and Branch Decision

This block is the execute stage of a small 32-bit processor. It takes two operands that earlier logic has already selected, runs one of four arithmetic or logical functions on them, and returns the result in the same cycle. The operand on the B side is always the left-hand operand: subtraction yields B minus A.

Alongside the result, the block works out a zero, a sign and a signed-overflow flag. These flags go into a three-bit condition register, but only on a rising clock edge and only when the flag-load enable is high. A branch evaluator reads the stored flags, not the flags of the current result, and turns a jump-condition code into a taken/not-taken decision. The fetch logic uses that decision to choose between the jump destination and the incremented program counter.

Top module: `exec_unit`

## Requirements
- R1: Function code 0 gives `result` = `opB` + `opA`, modulo 2^32.
- R2: Function code 1 gives `result` = `opB` − `opA`, modulo 2^32.
- R3: Function code 2 gives the bitwise AND of the operands. Function code 3 gives their bitwise XOR.
- R4: `result` is combinational. It follows the operands and the function code in the same cycle, without waiting for a clock edge.
- R5: The flag register loads only on a rising edge of `clk` at which `setCc` is high. At every other edge it keeps its value.
- R6: The loaded zero flag is 1 exactly when `result` was all zeros. The loaded sign flag equals bit 31 of `result`.
- R7: For add and subtract, the loaded overflow flag is 1 exactly when the signed two's-complement outcome does not fit in 32 bits. For AND and XOR it is loaded as 0.
- R8: While `rstN` is low, the zero flag is 1 and the sign and overflow flags are 0. The reset is asynchronous.
- R9: `brTaken` is computed combinationally from the stored flags, with lt = sign XOR overflow. The jump codes are: 0 always taken; 1 lt OR zero; 2 lt; 3 zero; 4 NOT zero; 5 NOT lt; 6 NOT lt AND NOT zero; 7 to 15 never taken.
- R10: Function codes 4 to 15 act as add, including how they set the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | Right-hand operand |
| opB | input | 32 | Left-hand operand |
| aluFun | input | 4 | Function select |
| setCc | input | 1 | Flag-load enable |
| jmpFun | input | 4 | Jump-condition code |
| result | output | 32 | ALU result |
| flagZero | output | 1 | Stored zero flag |
| flagSign | output | 1 | Stored sign flag |
| flagOvf | output | 1 | Stored overflow flag |
| brTaken | output | 1 | Branch decision from the stored flags |

## Verification
A flag load and a branch evaluation can happen in the same cycle. Because the block is correct only if the branch uses the flags stored before the edge, and not the result on the bus, the bench drives a new operation with `setCc` high and a jump code in the same cycle.

Before the edge, the bench compares `brTaken` with a model built from the flags it holds. After the edge, it compares the updated flags. Random operands are mixed with operands at 0x7FFFFFFF and 0x80000000 so that overflow and sign changes meet a pending jump.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_AND, OP_XOR} aluOpE;

  typedef struct packed {
    logic zero;
    logic sign;
    logic ovf;
  } ccT;

  typedef struct packed {
    aluOpE op;
    logic  arith;
    logic  load;
  } strobeT;

  localparam ccT CC_RESET = '{zero: 1'b1, sign: 1'b0, ovf: 1'b0};
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
#(
  parameter int FUN_W = 4,
  parameter int JMP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FUN_W-1:0] aluFun,
  input  logic             setCc,
  input  logic [JMP_W-1:0] jmpFun,
  input  ccT               ccQ,
  output strobeT           strb,
  output logic             brTaken
);
  logic lessThan;

  always_comb begin
    unique case (aluFun)
      FUN_W'(1): strb.op = OP_SUB;
      FUN_W'(2): strb.op = OP_AND;
      FUN_W'(3): strb.op = OP_XOR;
      default:   strb.op = OP_ADD;
    endcase
    strb.arith = (strb.op == OP_ADD) || (strb.op == OP_SUB);
    strb.load  = setCc;
  end

  assign lessThan = ccQ.sign ^ ccQ.ovf;

  always_comb begin
    unique case (jmpFun)
      JMP_W'(0): brTaken = 1'b1;
      JMP_W'(1): brTaken = lessThan | ccQ.zero;
      JMP_W'(2): brTaken = lessThan;
      JMP_W'(3): brTaken = ccQ.zero;
      JMP_W'(4): brTaken = !ccQ.zero;
      JMP_W'(5): brTaken = !lessThan;
      JMP_W'(6): brTaken = !lessThan && !ccQ.zero;
      default:   brTaken = 1'b0;
    endcase
  end

  p_always_r9: assert property (@(posedge clk) disable iff (!rstN)
    (jmpFun == JMP_W'(0)) |-> brTaken);
  p_ne_eq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (jmpFun == JMP_W'(4)) |-> (brTaken != ccQ.zero));
  p_unused_r9: assert property (@(posedge clk) disable iff (!rstN)
    (jmpFun > JMP_W'(6)) |-> !brTaken);
endmodule

// File: rtl/exec_dp.sv
module exec_dp
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  strobeT            strb,
  output logic [DATA_W-1:0] result,
  output ccT                ccQ
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] sum;
  logic              sumOvf;
  ccT                ccNext;

  // One adder serves both add and subtract: B + ~A + 1 for subtract.
  assign addend = (strb.op == OP_SUB) ? ~opA : opA;
  assign sum    = opB + addend + DATA_W'(strb.op == OP_SUB);
  assign sumOvf = (opB[MSB] == addend[MSB]) && (sum[MSB] != opB[MSB]);

  always_comb begin
    unique case (strb.op)
      OP_AND:  result = opB & opA;
      OP_XOR:  result = opB ^ opA;
      default: result = sum;
    endcase
    ccNext.zero = (result == '0);
    ccNext.sign = result[MSB];
    ccNext.ovf  = strb.arith && sumOvf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ccQ <= CC_RESET;
    else if (strb.load) ccQ <= ccNext;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(ccQ));
  p_zero_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (ccQ.zero == ($past(result) == '0)) && (ccQ.sign == $past(result[MSB])));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.arith) |=> !ccQ.ovf);
  p_reset_r8: assert property (@(posedge clk)
    $rose(rstN) |-> (ccQ == CC_RESET));
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FUN_W  = 4,
  parameter int JMP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FUN_W-1:0]  aluFun,
  input  logic              setCc,
  input  logic [JMP_W-1:0]  jmpFun,
  output logic [DATA_W-1:0] result,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOvf,
  output logic              brTaken
);
  strobeT strb;
  ccT     ccQ;

  exec_ctrl #(.FUN_W(FUN_W), .JMP_W(JMP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .aluFun(aluFun), .setCc(setCc),
    .jmpFun(jmpFun), .ccQ(ccQ), .strb(strb), .brTaken(brTaken)
  );

  exec_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .strb(strb),
    .result(result), .ccQ(ccQ)
  );

  assign flagZero = ccQ.zero;
  assign flagSign = ccQ.sign;
  assign flagOvf  = ccQ.ovf;
endmodule

// File: tb/exec_unit_tb.sv
module exec_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  aluFun = '0, jmpFun = '0;
  logic        setCc = 1'b0;
  logic [31:0] result;
  logic        flagZero, flagSign, flagOvf, brTaken;

  int compared = 0;
  int mismatched = 0;
  bit mZ = 1'b1, mS = 1'b0, mO = 1'b0;

  always #2 clk = ~clk;

  exec_unit u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .aluFun(aluFun),
    .setCc(setCc), .jmpFun(jmpFun), .result(result), .flagZero(flagZero),
    .flagSign(flagSign), .flagOvf(flagOvf), .brTaken(brTaken)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit refBranch(input int code, input bit z, input bit s, input bit o);
    bit lt = s ^ o;
    case (code)
      0: return 1'b1;
      1: return lt || z;
      2: return lt;
      3: return z;
      4: return !z;
      5: return !lt;
      6: return !lt && !z;
      default: return 1'b0;
    endcase
  endfunction

  // Drive one operation, check the result and branch before the edge, then update the model flags.
  task automatic step(input logic [31:0] a, input logic [31:0] b, input int fun,
                      input bit cc, input int jf);
    longint sa, sb, wide;
    logic [31:0] expR;
    bit ovf;
    string tag;
    @(negedge clk);
    opA = a; opB = b; aluFun = 4'(fun); setCc = cc; jmpFun = 4'(jf);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ovf = 1'b0;
    if (fun == 1) begin
      wide = sb - sa; tag = "R2 R4";
    end else if (fun == 2) begin
      wide = 0; tag = "R3 R4";
    end else if (fun == 3) begin
      wide = 0; tag = "R3 R4";
    end else begin
      wide = sb + sa; tag = (fun == 0) ? "R1 R4" : "R10 R4";
    end
    if (fun == 2)      expR = b & a;
    else if (fun == 3) expR = b ^ a;
    else begin
      expR = wide[31:0];
      ovf  = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    end
    #1;
    check(tag, result, expR);
    check("R9 stored-flag branch", {31'b0, brTaken}, {31'b0, refBranch(jf, mZ, mS, mO)});
    @(posedge clk);
    if (cc) begin
      mZ = (expR == 0); mS = expR[31]; mO = ovf;
    end
    @(negedge clk);
    #1;
    check(cc ? "R5 R6 R7 flags load" : "R5 flags hold",
          {29'b0, flagZero, flagSign, flagOvf}, {29'b0, mZ, mS, mO});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset flags", {29'b0, flagZero, flagSign, flagOvf}, 32'b100);
    @(negedge clk);
    rstN = 1'b1;
    // Overflow corners, including a flag load and a branch in the same cycle.
    step(32'h1, 32'h7FFFFFFF, 0, 1, 3);
    step(32'h1, 32'h80000000, 1, 1, 2);
    step(32'h80000000, 32'h0, 1, 1, 1);
    step(32'h80000000, 32'h80000000, 0, 1, 6);
    step(32'hFFFFFFFF, 32'h7FFFFFFF, 2, 1, 5);
    step(32'h7FFFFFFF, 32'h7FFFFFFF, 3, 1, 3);
    step(32'h5, 32'h5, 1, 1, 4);
    step(32'h1, 32'h7FFFFFFF, 0, 0, 2);
    step(32'h3, 32'h4, 9, 1, 12);
    for (int i = 0; i < 600; i++)
      step($urandom, (i % 5 == 0) ? 32'h80000000 : $urandom, int'($urandom_range(0, 15)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule